// File: doc/BRIEF.md
# BFloat16 Lane Minimum Slice

This block picks, lane by lane, the smaller of two BFloat16 values (1 sign bit, 8 exponent bits, 7 fraction bits). A parameterised number of identical lanes sits side by side, so the block serves as one slice of a wider vector datapath. Each lane's result is combinational. Minimum never rounds, so there is no rounding logic.

Two static control inputs select how signed zeros and NaNs are treated. With the alternate-handling bit low, the unit follows IEEE-style ordering with -0 below +0. In that mode a NaN input produces either the propagated and quieted NaN, or a fixed default NaN when default-NaN mode is on. With the alternate-handling bit high, a NaN on either side, or a pair of zeros, simply passes the second operand through untouched.

A sticky invalid flag records any signalling NaN seen while the alternate-handling bit is low. Only reset clears it.

Top module: `bf16_min_slice`

## Requirements
- R1: For non-NaN operands of different sign, the negative one is returned. Infinities take part as the extreme values.
- R2: For non-NaN operands of equal sign, the result is the one of smaller magnitude when both are positive. It is the one of larger magnitude when both are negative.
- R3: With alt_mode_i=0, the minimum of 16'h8000 (-0) and 16'h0000 (+0) is 16'h8000 in either operand order.
- R4: A NaN has exponent 8'hFF and a non-zero fraction. It is signalling when fraction bit 6 (word bit 6) is 0. With alt_mode_i=0 and dflt_nan_i=0, a NaN input returns one NaN chosen in this order: signalling A, signalling B, quiet A, quiet B. The chosen NaN is returned with word bit 6 forced to 1.
- R5: With alt_mode_i=0 and dflt_nan_i=1, any NaN input returns 16'h7FC0.
- R6: With alt_mode_i=1 and both operands zero (any signs), the result equals operand B bit for bit.
- R7: With alt_mode_i=1 and either operand a NaN, the result equals operand B bit for bit, whatever dflt_nan_i is.
- R8: invalid_o rises at the clock edge that samples alt_mode_i=0 together with a signalling NaN on any lane. It then stays high until reset. A signalling NaN sampled with alt_mode_i=1 does not set it, and reset drives it to 0.
- R9: Lanes are independent. Lane k takes bits [16k+15:16k] of each operand bus and drives the same bits of min_o.
- R10: min_o follows the inputs in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the invalid flag |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alt_mode_i | input | 1 | Alternate zero/NaN handling |
| dflt_nan_i | input | 1 | Default-NaN enable (alt_mode_i=0 only) |
| op_a_i | input | 16*LANES | First operands, lane k at [16k+15:16k] |
| op_b_i | input | 16*LANES | Second operands |
| min_o | output | 16*LANES | Per-lane minimum |
| invalid_o | output | 1 | Sticky signalling-NaN flag |

## Verification
Two functions can act in the same cycle: producing a NaN result on a lane and raising the sticky flag. Lanes can also disagree, with one lane holding a signalling NaN while the other compares ordinary numbers. The bench sweeps every pair from a set of boundary encodings across all four mode settings, with swapped operands on the second lane. It judges each lane's result against an arithmetic ordering key computed in the bench, and it judges the flag after each edge against a running model.

// File: rtl/bf16_min_pkg.sv
package bf16_min_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 7;
  localparam int unsigned BF_W   = 1 + EXP_W + FRAC_W;
  localparam logic [BF_W-1:0] DEFAULT_NAN = 16'h7FC0;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } bf16_t;

  function automatic logic f_is_nan(bf16_t x);
    return (&x.exp) && (|x.frac);
  endfunction

  function automatic logic f_is_snan(bf16_t x);
    return f_is_nan(x) && !x.frac[FRAC_W-1];
  endfunction

  function automatic logic f_is_zero(bf16_t x);
    return ~|{x.exp, x.frac};
  endfunction
endpackage

// File: rtl/bf16_order_cmp.sv
module bf16_order_cmp
  import bf16_min_pkg::*;
(
  input  bf16_t a_i,
  input  bf16_t b_i,
  output logic  a_lt_b_o
);
  localparam int unsigned MAG_W = EXP_W + FRAC_W;
  logic [MAG_W-1:0] mag_a, mag_b;
  assign mag_a = {a_i.exp, a_i.frac};
  assign mag_b = {b_i.exp, b_i.frac};

  // sign-magnitude order; -0 sorts below +0 via the sign branch
  always_comb begin
    if (a_i.sign != b_i.sign) a_lt_b_o = a_i.sign;
    else if (!a_i.sign)       a_lt_b_o = mag_a < mag_b;
    else                      a_lt_b_o = mag_a > mag_b;
  end
endmodule

// File: rtl/bf16_min_lane.sv
module bf16_min_lane
  import bf16_min_pkg::*;
(
  input  logic  alt_i,
  input  logic  dn_i,
  input  bf16_t a_i,
  input  bf16_t b_i,
  output bf16_t res_o,
  output logic  snan_o
);
  logic a_nan, b_nan, a_snan, b_snan, both_zero, any_nan, a_lt_b;
  bf16_t nan_pick, nan_quiet;

  assign a_nan     = f_is_nan(a_i);
  assign b_nan     = f_is_nan(b_i);
  assign a_snan    = f_is_snan(a_i);
  assign b_snan    = f_is_snan(b_i);
  assign any_nan   = a_nan | b_nan;
  assign both_zero = f_is_zero(a_i) & f_is_zero(b_i);
  assign snan_o    = a_snan | b_snan;

  bf16_order_cmp u_cmp (.a_i(a_i), .b_i(b_i), .a_lt_b_o(a_lt_b));

  always_comb begin
    if (a_snan)      nan_pick = a_i;
    else if (b_snan) nan_pick = b_i;
    else if (a_nan)  nan_pick = a_i;
    else             nan_pick = b_i;
    nan_quiet = nan_pick;
    nan_quiet.frac[FRAC_W-1] = 1'b1;
  end

  always_comb begin
    if (alt_i && (any_nan || both_zero)) res_o = b_i;
    else if (any_nan)                   res_o = dn_i ? bf16_t'(DEFAULT_NAN) : nan_quiet;
    else                                res_o = a_lt_b ? a_i : b_i;
  end
endmodule

// File: rtl/bf16_invalid_sticky.sv
module bf16_invalid_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end

  AST_FLAG_SET:  assert property (@(posedge clk_i) disable iff (!rst_ni) set_i  |=> flag_o); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) flag_o |=> flag_o); // R8
endmodule

// File: rtl/bf16_min_slice.sv
module bf16_min_slice
  import bf16_min_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 alt_mode_i,
  input  logic                 dflt_nan_i,
  input  logic [BF_W*LANES-1:0] op_a_i,
  input  logic [BF_W*LANES-1:0] op_b_i,
  output logic [BF_W*LANES-1:0] min_o,
  output logic                 invalid_o
);
  logic [LANES-1:0] lane_snan;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bf16_t a_k, b_k, r_k;
    assign a_k = op_a_i[k*BF_W +: BF_W];
    assign b_k = op_b_i[k*BF_W +: BF_W];

    bf16_min_lane u_lane (
      .alt_i (alt_mode_i),
      .dn_i  (dflt_nan_i),
      .a_i   (a_k),
      .b_i   (b_k),
      .res_o (r_k),
      .snan_o(lane_snan[k])
    );
    assign min_o[k*BF_W +: BF_W] = r_k;

    AST_ALT_NAN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alt_mode_i && (f_is_nan(a_k) || f_is_nan(b_k))) |-> r_k == b_k); // R7
    AST_NAN_QUIETED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!alt_mode_i && !dflt_nan_i && (f_is_nan(a_k) || f_is_nan(b_k)))
        |-> (f_is_nan(r_k) && r_k.frac[FRAC_W-1])); // R4
    AST_DEFAULT_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!alt_mode_i && dflt_nan_i && (f_is_nan(a_k) || f_is_nan(b_k)))
        |-> r_k == bf16_t'(DEFAULT_NAN)); // R5
    AST_RESULT_IS_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!f_is_nan(a_k) && !f_is_nan(b_k)) |-> (r_k == a_k || r_k == b_k)); // R1
  end

  bf16_invalid_sticky u_sticky (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (!alt_mode_i && (|lane_snan)),
    .flag_o(invalid_o)
  );
endmodule

// File: tb/sim_bf16_min_slice.sv
module sim_bf16_min_slice;
  localparam int LANES = 2;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic alt, dn;
  logic [16*LANES-1:0] a, b, r;
  logic inv;
  int total = 0, bad = 0;
  logic exp_inv = 1'b0;
  logic [15:0] vals [21];

  always #4 clk = ~clk;

  bf16_min_slice #(.LANES(LANES)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .alt_mode_i(alt), .dflt_nan_i(dn),
    .op_a_i(a), .op_b_i(b), .min_o(r), .invalid_o(inv));

  function automatic bit is_nan(logic [15:0] x);
    return x[14:7] == 8'hFF && x[6:0] != 0;
  endfunction
  function automatic bit is_snan(logic [15:0] x);
    return is_nan(x) && !x[6];
  endfunction
  // ordering key: -0 -> -1, negatives further below
  function automatic int okey(logic [15:0] x);
    return x[15] ? -int'(x[14:0]) - 1 : int'(x[14:0]);
  endfunction
  function automatic logic [15:0] ref_min(bit al, bit d, logic [15:0] x, logic [15:0] y);
    bit nx = is_nan(x), ny = is_nan(y);
    if (al && (nx || ny)) return y;                             // R7
    if (al && x[14:0] == 0 && y[14:0] == 0) return y;           // R6
    if (nx || ny) begin
      if (d) return 16'h7FC0;                                   // R5
      if (is_snan(x)) return x | 16'h0040;                      // R4
      if (is_snan(y)) return y | 16'h0040;
      if (nx) return x | 16'h0040;
      return y | 16'h0040;
    end
    return (okey(x) <= okey(y)) ? x : y;                         // R1 R2 R3
  endfunction

  function automatic string tag(bit al, bit d, logic [15:0] x, logic [15:0] y);
    if (al && (is_nan(x) || is_nan(y))) return "R7";
    if (al && x[14:0] == 0 && y[14:0] == 0) return "R6";
    if (is_nan(x) || is_nan(y)) return d ? "R5" : "R4";
    if (x[14:0] == 0 && y[14:0] == 0) return "R3";
    if (x[15] != y[15]) return "R1";
    return "R2";
  endfunction

  task automatic apply(bit al, bit d, logic [15:0] x0, logic [15:0] y0,
                       logic [15:0] x1, logic [15:0] y1);
    logic [15:0] e0, e1;
    @(negedge clk);
    alt = al; dn = d; a = {x1, x0}; b = {y1, y0};
    #1;
    e0 = ref_min(al, d, x0, y0);
    e1 = ref_min(al, d, x1, y1);
    total++; // R10 same-cycle result, R9 lane 0
    if (r[15:0] !== e0) begin
      bad++;
      $display("FAIL %s lane0 a=%h b=%h alt=%0b dn=%0b got=%h exp=%h",
               tag(al, d, x0, y0), x0, y0, al, d, r[15:0], e0);
    end
    total++; // R9 lane 1
    if (r[31:16] !== e1) begin
      bad++;
      $display("FAIL %s lane1 a=%h b=%h alt=%0b dn=%0b got=%h exp=%h",
               tag(al, d, x1, y1), x1, y1, al, d, r[31:16], e1);
    end
    @(posedge clk);
    if (!al && (is_snan(x0) || is_snan(y0) || is_snan(x1) || is_snan(y1))) exp_inv = 1'b1;
    #1;
    total++;
    if (inv !== exp_inv) begin
      bad++;
      $display("FAIL R8 invalid got=%b exp=%b", inv, exp_inv);
    end
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] s;
    vals = '{16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h007F, 16'h0080,
             16'h3F80, 16'hBF80, 16'h3F81, 16'hBF81, 16'h7F7F, 16'hFF7F,
             16'h7F80, 16'hFF80, 16'h7F81, 16'hFF81, 16'h7FC0, 16'hFFC1,
             16'h7FA0, 16'h4000, 16'hC000};
    alt = 0; dn = 0; a = '0; b = '0;
    #20;
    total++;
    if (inv !== 1'b0) begin bad++; $display("FAIL R8 reset got=%b exp=0", inv); end
    @(negedge clk); rst_ni = 1'b1;
    // alt modes first so R8 no-set under alt=1 is visible
    for (int m = 3; m >= 0; m--)
      for (int i = 0; i < 21; i++)
        for (int j = 0; j < 21; j++)
          apply(m[1], m[0], vals[i], vals[j], vals[j], vals[i]);
    // explicit signed-zero corners
    apply(0, 0, 16'h8000, 16'h0000, 16'h0000, 16'h8000); // R3
    apply(1, 1, 16'h8000, 16'h0000, 16'h0000, 16'h8000); // R6
    // reset clears flag
    @(negedge clk); rst_ni = 1'b0; #1;
    exp_inv = 1'b0;
    total++;
    if (inv !== 1'b0) begin bad++; $display("FAIL R8 clear got=%b exp=0", inv); end
    @(negedge clk); rst_ni = 1'b1;
    s = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] p, q, u, v;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; p = s;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; q = s;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; u = s;
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]}; v = s;
      apply(n[1], n[0], p, q, u, v);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule